// File: doc/BRIEF.md
# Decimator Start-Up Path Sequencer

This block governs how one delta-sigma decimation channel comes out of power-up or reset. A one-bit modulator stream, qualified by a modulator-clock enable, feeds two decimators at once: a single-stage boxcar that is settled after one output period, and a three-stage integrate-and-comb (sinc3) filter that needs three output periods. A fixed number of initial modulator periods is discarded before either filter sees data. The first two output samples are taken from the boxcar path; from the third sample on, the sinc3 result owns the output for good and the boxcar path stops accumulating.

A power-on settling interval, counted on the free-running clock, holds the channel idle after the hardware reset. Its end is shown by the power-on-complete output and by the active-low data-ready line rising. Each new sample is then announced by data-ready falling and returns high a fixed number of modulator ticks later. A reset request (command or pin, one clock wide) restarts the discard wait and the two fast-path samples without repeating the power-on interval. It also returns the clock-source choice to the external clock by clearing the internal-oscillator select bit.

Top module: `dss_startup_seq`

## Requirements
- R1: After `rst_n` is released, `por_done` and `drdy_n` stay 0 for exactly POR_CYCLES (64) clock edges and are both 1 after that edge; `mod_en` pulses during this interval are not counted.
- R2: The first WAIT_TICKS (300) accepted modulator ticks after the power-on interval or a reset request are discarded; their bits reach neither filter.
- R3: Output sample k is signalled by `drdy_n` falling in the clock after the accepted tick numbered 300 + 1024·k (k = 1, 2, 3, ...).
- R4: Samples 1 and 2 carry the boxcar value (2·ones − 1024)·2^20 over their 1024 input bits, where ones is the count of 1 bits, and `path_sinc` reads 0 with them.
- R5: Sample 3 and every later sample carry the sinc3 result with `path_sinc` = 1; for a constant-density input over the last three periods it equals density·2^30 (all ones +2^30, all zeros −2^30, repeating 1,1,1,0 gives +2^29).
- R6: After each fall, `drdy_n` stays 0 for three further accepted ticks and returns to 1 on the fourth.
- R7: Clock cycles with `mod_en` = 0 do not advance the wait, the filters or the data-ready timing.
- R8: A one-clock `rst_req` makes `drdy_n` = 1, `path_sinc` = 0 and `sample_out` = 0 in the next clock, skips the power-on interval and restarts from R2, so the next two samples come from the boxcar path again.
- R9: `osc_set` sets `int_osc_sel` to 1; `rst_req` or `rst_n` low clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| rst_req | input | 1 | One-clock reset request (command or pin) |
| mod_en | input | 1 | Modulator-clock enable, one accepted tick per high cycle |
| mod_bit | input | 1 | Modulator output bit, 1 = +1, 0 = −1 |
| osc_set | input | 1 | Selects the internal oscillator |
| por_done | output | 1 | Power-on settling interval complete |
| drdy_n | output | 1 | Active-low data-ready strobe |
| sample_out | output | DATA_W (32) | Signed output sample, full scale ±2^30 |
| path_sinc | output | 1 | 1 when the current sample came from the sinc3 path |
| int_osc_sel | output | 1 | Internal oscillator selected |

## Verification
The stream is driven with all ones, all zeros, a ones-then-zeros-then-1110 sequence, and with opposite bit values during the discard wait. Filling the wait with the opposite value shows whether discarded bits leak into sample 1, and switching the level between periods 1 and 2 exposes a window misplaced by even one tick or a handover made one sample early, since the partial sinc3 value differs from the boxcar value. Runs at full and half modulator rate separate tick counting from clock counting, and a reset request after the sinc3 handover shows the return to the fast path without a second power-on interval.

// File: rtl/dss_pkg.sv
// Shared types for the decimator start-up sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package dss_pkg;

    // Sequencer phase: discarding the initial ticks, or feeding the filters.
    typedef enum logic [0:0] {
        PH_WAIT = 1'b0,
        PH_RUN  = 1'b1
    } seq_phase_e;

    // Number of integrator and comb stages in the slow path.
    localparam int unsigned SINC_ORDER = 3;

    // Number of fast-path samples issued before the handover.
    localparam int unsigned FAST_SAMPLES = 2;

endpackage

// File: rtl/dss_por_timer.sv
// Power-on settling timer.
// Counts POR_CYCLES free-running clocks after the hardware reset is released
// and then holds por_done high until the next hardware reset.
// Assumes: POR_CYCLES >= 2; rst_n is synchronous and active low.
module dss_por_timer #(
    parameter int unsigned POR_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic por_done
);
    localparam int unsigned CNT_W = $clog2(POR_CYCLES);

    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    // Advance the settling count and latch completion on the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (cnt_q == CNT_W'(POR_CYCLES - 1)) begin
                done_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign por_done = done_q;

    // R1: once complete, the power-on indication never drops without reset.
    p_por_latched_r1: assert property (@(posedge clk) disable iff (!rst_n)
        por_done |=> por_done);

endmodule

// File: rtl/dss_boxcar.sv
// Fast-settling single-stage boxcar decimator.
// Sums the ones in each period of DECIM input bits and presents the
// bipolar result, scaled to the common output width, including the
// bit being accepted in the current cycle.
// Assumes: DECIM is a power of two; en and last come from the sequencer.
module dss_boxcar #(
    parameter int unsigned DECIM = 1024,
    parameter int unsigned OUT_W = 3 * $clog2(DECIM) + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    en,
    input  logic                    last,
    input  logic                    din,
    output logic signed [OUT_W-1:0] val
);
    localparam int unsigned LOG_D = $clog2(DECIM);
    localparam int unsigned CNT_W = LOG_D + 1;
    localparam int unsigned SHIFT = 2 * LOG_D;

    logic [CNT_W-1:0]        acc_q;
    logic [CNT_W-1:0]        sum_now;
    logic signed [OUT_W-1:0] sum_ext;
    logic signed [OUT_W-1:0] bipolar;

    // Count including the bit presented in this cycle.
    always_comb begin
        sum_now = acc_q + CNT_W'(din);
    end

    // Map the ones count to a signed value and scale it to full width.
    always_comb begin
        sum_ext = $signed({{(OUT_W - CNT_W){1'b0}}, sum_now});
        bipolar = (sum_ext <<< 1) - $signed(OUT_W'(DECIM));
        val     = bipolar <<< SHIFT;
    end

    // Accumulate ones; restart at each period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= last ? '0 : sum_now;
        end
    end

    // R4: the running count never reaches a full period before its last bit.
    p_acc_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> acc_q <= CNT_W'(DECIM - 1));

endmodule

// File: rtl/dss_sinc3.sv
// Third-order integrate-and-comb decimator.
// Integrators run on every fed bit (+1 or -1); the comb section runs once
// per DECIM fed bits and produces the result used at that boundary.
// Assumes: DECIM is a power of two; OUT_W holds +/- DECIM**3 and the
// integrators may wrap, which the combs undo.
module dss_sinc3 #(
    parameter int unsigned DECIM = 1024,
    parameter int unsigned OUT_W = 3 * $clog2(DECIM) + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    en,
    input  logic                    dec,
    input  logic                    din,
    output logic signed [OUT_W-1:0] val
);
    import dss_pkg::*;

    localparam int unsigned N = SINC_ORDER;

    logic signed [OUT_W-1:0] x_in;
    logic signed [OUT_W-1:0] integ_q [N];
    logic signed [OUT_W-1:0] integ_n [N];
    logic signed [OUT_W-1:0] dly_q   [N];
    logic signed [OUT_W-1:0] comb_n  [N];

    // Map the modulator bit to +1 / -1.
    always_comb begin
        x_in = din ? OUT_W'(1) : {OUT_W{1'b1}};
    end

    for (genvar k = 0; k < N; k++) begin : g_stage
        // Integrator stage k: next value including this cycle's input.
        if (k == 0) begin : g_first
            always_comb integ_n[k] = integ_q[k] + x_in;
            always_comb comb_n[k]  = integ_n[N-1] - dly_q[k];
        end else begin : g_rest
            always_comb integ_n[k] = integ_q[k] + integ_n[k-1];
            always_comb comb_n[k]  = comb_n[k-1] - dly_q[k];
        end

        // Integrator register, updated on every fed bit.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                integ_q[k] <= '0;
            end else if (en) begin
                integ_q[k] <= integ_n[k];
            end
        end

        // Comb delay register, updated once per decimation boundary.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                dly_q[k] <= '0;
            end else if (en && dec) begin
                dly_q[k] <= (k == 0) ? integ_n[N-1] : comb_n[k-1];
            end
        end
    end

    assign val = comb_n[N-1];

    // R7: without a fed bit the first integrator holds its value.
    p_integ_hold_r7: assert property (@(posedge clk) disable iff (!rst_n || clr)
        !en |=> $stable(integ_q[0]));

endmodule

// File: rtl/dss_ctrl.sv
// Start-up sequencer control.
// Discards the initial modulator ticks, counts positions within each output
// period, chooses the fast path for the first samples and the sinc3 path
// afterwards, registers the output and times the data-ready strobe.
// Assumes: DECIM is a power of two; WAIT_TICKS and DRDY_TICKS >= 2 and
// DRDY_TICKS < DECIM.
module dss_ctrl #(
    parameter int unsigned DECIM      = 1024,
    parameter int unsigned WAIT_TICKS = 300,
    parameter int unsigned DRDY_TICKS = 4,
    parameter int unsigned OUT_W      = 3 * $clog2(DECIM) + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    restart,
    input  logic                    por_done,
    input  logic                    mod_en,
    input  logic signed [OUT_W-1:0] box_val,
    input  logic signed [OUT_W-1:0] sinc_val,
    output logic                    feed,
    output logic                    dec,
    output logic                    fast_en,
    output logic signed [OUT_W-1:0] data_q,
    output logic                    path_sinc,
    output logic                    drdy_n
);
    import dss_pkg::*;

    localparam int unsigned WC_W = $clog2(WAIT_TICKS);
    localparam int unsigned PH_W = $clog2(DECIM);
    localparam int unsigned DC_W = $clog2(DRDY_TICKS);

    seq_phase_e      phase_q;
    logic [WC_W-1:0] wait_q;
    logic [PH_W-1:0] pos_q;
    logic [1:0]      samp_q;
    logic [DC_W-1:0] dcnt_q;
    logic            drdy_q;
    logic            tick;

    // Qualify modulator ticks by the end of the power-on interval.
    always_comb begin
        tick    = mod_en && por_done;
        feed    = tick && (phase_q == PH_RUN);
        dec     = feed && (pos_q == PH_W'(DECIM - 1));
        fast_en = (samp_q < 2'(FAST_SAMPLES));
    end

    // Discard wait: count the initial ticks, then open the filter feed.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase_q <= PH_WAIT;
            wait_q  <= '0;
        end else if (tick && phase_q == PH_WAIT) begin
            if (wait_q == WC_W'(WAIT_TICKS - 1)) begin
                phase_q <= PH_RUN;
            end else begin
                wait_q <= wait_q + 1'b1;
            end
        end
    end

    // Position of the fed bit within the current output period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pos_q <= '0;
        end else if (feed) begin
            pos_q <= dec ? '0 : pos_q + 1'b1;
        end
    end

    // Count issued samples, saturating once the handover has happened.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            samp_q <= '0;
        end else if (dec && fast_en) begin
            samp_q <= samp_q + 1'b1;
        end
    end

    // Output register: fast result first, sinc3 result after the handover.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            data_q    <= '0;
            path_sinc <= 1'b0;
        end else if (dec) begin
            data_q    <= fast_en ? box_val : sinc_val;
            path_sinc <= !fast_en;
        end
    end

    // Data-ready timing: drop on a new sample, release after DRDY_TICKS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            drdy_q <= 1'b1;
            dcnt_q <= '0;
        end else if (dec) begin
            drdy_q <= 1'b0;
            dcnt_q <= '0;
        end else if (tick && !drdy_q) begin
            if (dcnt_q == DC_W'(DRDY_TICKS - 1)) begin
                drdy_q <= 1'b1;
            end else begin
                dcnt_q <= dcnt_q + 1'b1;
            end
        end
    end

    assign drdy_n = por_done && drdy_q;

    // R3: every decimation boundary is announced by data-ready low next cycle.
    p_fall_on_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec && !restart |=> !drdy_n);

    // R4: samples issued while the fast path owns the output are marked fast.
    p_fast_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec && fast_en && !restart |=> !path_sinc);

    // R5: once the sinc3 path owns the output it keeps it until a restart.
    p_sinc_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        path_sinc && !restart |=> path_sinc);

    // R8: a restart after power-on returns to the idle, fast-path state.
    p_restart_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart && por_done |=> drdy_n && !path_sinc);

    // R2: nothing is fed while the discard wait is still running.
    p_no_feed_in_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_WAIT) |-> !dec);

endmodule

// File: rtl/dss_startup_seq.sv
// Decimator start-up path sequencer, top level.
// Ties the power-on timer, both decimators and the control together and
// holds the internal-oscillator select bit, which every reset clears.
// Assumes: rst_n synchronous active low; rst_req one clock wide;
// DECIM a power of two.
module dss_startup_seq #(
    parameter int unsigned DECIM      = 1024,
    parameter int unsigned WAIT_TICKS = 300,
    parameter int unsigned DRDY_TICKS = 4,
    parameter int unsigned POR_CYCLES = 64,
    parameter int unsigned DATA_W     = 3 * $clog2(DECIM) + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rst_req,
    input  logic                     mod_en,
    input  logic                     mod_bit,
    input  logic                     osc_set,
    output logic                     por_done,
    output logic                     drdy_n,
    output logic signed [DATA_W-1:0] sample_out,
    output logic                     path_sinc,
    output logic                     int_osc_sel
);
    logic                     feed;
    logic                     dec;
    logic                     fast_en;
    logic signed [DATA_W-1:0] box_val;
    logic signed [DATA_W-1:0] sinc_val;

    dss_por_timer #(
        .POR_CYCLES(POR_CYCLES)
    ) u_por (
        .clk     (clk),
        .rst_n   (rst_n),
        .por_done(por_done)
    );

    dss_ctrl #(
        .DECIM     (DECIM),
        .WAIT_TICKS(WAIT_TICKS),
        .DRDY_TICKS(DRDY_TICKS),
        .OUT_W     (DATA_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (rst_req),
        .por_done (por_done),
        .mod_en   (mod_en),
        .box_val  (box_val),
        .sinc_val (sinc_val),
        .feed     (feed),
        .dec      (dec),
        .fast_en  (fast_en),
        .data_q   (sample_out),
        .path_sinc(path_sinc),
        .drdy_n   (drdy_n)
    );

    dss_boxcar #(
        .DECIM(DECIM),
        .OUT_W(DATA_W)
    ) u_box (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (rst_req),
        .en   (feed && fast_en),
        .last (dec),
        .din  (mod_bit),
        .val  (box_val)
    );

    dss_sinc3 #(
        .DECIM(DECIM),
        .OUT_W(DATA_W)
    ) u_sinc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (rst_req),
        .en   (feed),
        .dec  (dec),
        .din  (mod_bit),
        .val  (sinc_val)
    );

    // Clock-source select bit: set on request, back to external on any reset.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_req) begin
            int_osc_sel <= 1'b0;
        end else if (osc_set) begin
            int_osc_sel <= 1'b1;
        end
    end

    // R9: a reset request always leaves the external clock selected.
    p_osc_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !int_osc_sel);

endmodule

// File: tb/dss_startup_seq_test.sv
module dss_startup_seq_test;
    localparam int POR   = 64;
    localparam int WAITT = 300;
    localparam int DEC   = 1024;
    localparam int FS    = 1073741824;   // 2**30
    localparam int HALF  = 536870912;    // 2**29

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_req = 1'b0;
    logic        mod_en = 1'b0;
    logic        mod_bit = 1'b0;
    logic        osc_set = 1'b0;
    logic        por_done;
    logic        drdy_n;
    logic signed [31:0] sample_out;
    logic        path_sinc;
    logic        int_osc_sel;

    int total = 0;
    int bad = 0;
    int ticks = 0;
    int n_samp = 0;
    logic prev_drdy = 1'b0;
    logic signed [31:0] sv [1:8];
    int                 st [1:8];
    logic               sp [1:8];
    bit                 finished = 1'b0;

    always #4 clk = ~clk;

    dss_startup_seq #(
        .DECIM(DEC), .WAIT_TICKS(WAITT), .DRDY_TICKS(4), .POR_CYCLES(POR)
    ) uut (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .mod_en(mod_en),
        .mod_bit(mod_bit), .osc_set(osc_set), .por_done(por_done),
        .drdy_n(drdy_n), .sample_out(sample_out), .path_sinc(path_sinc),
        .int_osc_sel(int_osc_sel)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic bit_for(input int mode, input int t);
        int p;
        int q;
        if (t <= WAITT) return (mode == 0 || mode == 3) ? 1'b0 : 1'b1;
        q = t - WAITT - 1;
        p = q / DEC + 1;
        case (mode)
            0, 3:    return 1'b1;
            1:       return (p == 1) ? 1'b1 : (p == 2) ? 1'b0 : ((q % 4) != 3);
            default: return 1'b0;
        endcase
    endfunction

    // One clock with the given enable/bit; records each data-ready fall.
    task automatic step(input logic en, input logic b);
        mod_en = en;
        mod_bit = b;
        @(posedge clk);
        @(negedge clk);
        if (en) ticks++;
        if (prev_drdy && !drdy_n && n_samp < 8) begin
            n_samp++;
            sv[n_samp] = sample_out;
            st[n_samp] = ticks;
            sp[n_samp] = path_sinc;
        end
        prev_drdy = drdy_n;
        mod_en = 1'b0;
    endtask

    task automatic run_ticks(input int mode, input int upto, input bit half);
        while (ticks < upto) begin
            if (half) step(1'b0, 1'b0);
            step(1'b1, bit_for(mode, ticks + 1));
        end
    endtask

    task automatic clear_log();
        ticks = 0;
        n_samp = 0;
        prev_drdy = drdy_n;
    endtask

    // R1: power-on interval length, outputs during it, enables ignored.
    task automatic t_power_on();
        @(negedge clk);
        rst_n = 1'b0;
        mod_en = 1'b1;
        mod_bit = 1'b1;
        repeat (3) @(negedge clk);
        chk(sample_out == 0 && !path_sinc, "R1 outputs in reset", sample_out, 0);
        chk(int_osc_sel == 1'b0, "R9 osc clear in reset", int_osc_sel, 0);
        rst_n = 1'b1;
        for (int k = 1; k <= POR; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == POR - 1)
                chk(!por_done && !drdy_n, "R1 still settling", {por_done, drdy_n}, 0);
            if (k == POR)
                chk(por_done && drdy_n, "R1 settled", {por_done, drdy_n}, 3);
        end
        mod_en = 1'b0;
        clear_log();
    endtask

    // Scenario: all ones after a zero-filled wait; timing, paths, strobe width.
    task automatic t_all_ones();
        t_power_on();
        run_ticks(0, WAITT + DEC + 3, 1'b0);
        chk(n_samp == 1 && st[1] == WAITT + DEC, "R3 first sample tick", st[1], WAITT + DEC);
        chk(sv[1] == FS, "R2 R4 first fast sample", sv[1], FS);
        chk(sp[1] == 1'b0, "R4 first path", sp[1], 0);
        chk(drdy_n == 1'b0, "R6 low after 3 ticks", drdy_n, 0);
        run_ticks(0, WAITT + DEC + 4, 1'b0);
        chk(drdy_n == 1'b1, "R6 high after 4 ticks", drdy_n, 1);
        run_ticks(0, WAITT + 5 * DEC + 10, 1'b0);
        chk(sv[2] == FS && sp[2] == 1'b0, "R4 second fast sample", sv[2], FS);
        chk(st[3] == WAITT + 3 * DEC, "R3 third sample tick", st[3], WAITT + 3 * DEC);
        chk(sp[3] == 1'b1, "R5 handover path", sp[3], 1);
        chk(sv[3] == FS, "R5 sinc3 settled ones", sv[3], FS);
        chk(sv[5] == FS && sp[5], "R5 later sinc3 sample", sv[5], FS);
    endtask

    // Scenario: ones, zeros, then 1110; one-filled wait.
    task automatic t_level_steps();
        t_power_on();
        run_ticks(1, WAITT + 5 * DEC + 10, 1'b0);
        chk(sv[1] == FS, "R2 window excludes wait", sv[1], FS);
        chk(sv[2] == -FS && sp[2] == 1'b0, "R4 second sample is boxcar", sv[2], -FS);
        chk(sv[5] == HALF && sp[5], "R5 sinc3 density 3/4", sv[5], HALF);
    endtask

    // Scenario: half-rate enable with all zeros.
    task automatic t_half_rate();
        t_power_on();
        run_ticks(2, WAITT + 3 * DEC + 5, 1'b1);
        chk(st[1] == WAITT + DEC, "R7 timing in ticks", st[1], WAITT + DEC);
        chk(sv[1] == -FS && !sp[1], "R7 fast zeros", sv[1], -FS);
        chk(sv[3] == -FS && sp[3], "R7 sinc3 zeros", sv[3], -FS);
    endtask

    // Scenario: reset request after handover; oscillator select.
    task automatic t_reset_request();
        osc_set = 1'b1;
        @(negedge clk);
        osc_set = 1'b0;
        chk(int_osc_sel == 1'b1, "R9 osc set", int_osc_sel, 1);
        chk(path_sinc == 1'b1, "R8 sinc3 before request", path_sinc, 1);
        rst_req = 1'b1;
        @(negedge clk);
        rst_req = 1'b0;
        chk(drdy_n && !path_sinc && sample_out == 0, "R8 idle after request",
            {drdy_n, path_sinc}, 2);
        chk(int_osc_sel == 1'b0, "R9 osc cleared by request", int_osc_sel, 0);
        chk(por_done == 1'b1, "R8 no second power-on", por_done, 1);
        clear_log();
        run_ticks(3, WAITT + 3 * DEC + 2, 1'b0);
        chk(st[1] == WAITT + DEC, "R8 restart timing", st[1], WAITT + DEC);
        chk(sv[1] == FS && !sp[1], "R8 fast path again", sv[1], FS);
        chk(st[3] == WAITT + 3 * DEC && sp[3], "R8 handover again", st[3], WAITT + 3 * DEC);
        osc_set = 1'b1;
        @(negedge clk);
        osc_set = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(int_osc_sel == 1'b0, "R9 osc cleared by rst_n", int_osc_sel, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        t_all_ones();
        t_level_steps();
        t_half_rate();
        t_reset_request();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule